// File: doc/BRIEF.md
# SPI Register Access Target

This block is the control-path target of an SPI slave port. A host reaches a small 32-bit register file through framed transactions. Each frame opens with a two-byte header: the first byte carries a control flag, a write flag and the top five bits of a 13-bit register address, and the second byte carries the low eight address bits. A write follows the header with four data bytes, most significant first. A read follows the header with one turnaround byte, after which the target shifts the addressed register out, most significant byte first.

A static pin, sampled only while reset is held, selects a checked mode. In that mode every frame carries CRC-8 bytes: one after the header, and one after the data word in either direction. A read also gains a zero byte before the data. A write whose header or data check fails is dropped. It sets a sticky error bit in the status register instead, and that bit drives an active-low interrupt unless it is masked. The register file holds an identification word, a software reset trigger, the status word and the interrupt mask.

The SPI pins run in mode 0: data is sampled on the rising SCLK edge and changed on the falling edge, in 8-bit words, with an active-low select. The pins are resampled in the block's own clock, so SCLK must be several times slower than that clock.

Top module: `spi_reg_target`

## Requirements
- R1: Header byte 0 bit 7 is the control flag, bit 5 is the write flag, and bits 4:0 are address bits 12:8. Header byte 1 is address bits 7:0. All 13 address bits are decoded, so 0x10D is not 0x0D.
- R2: In plain mode a read is header, one turnaround byte (the target outputs zero), then the 32-bit register most significant byte first.
- R3: In plain mode a write is header followed by four data bytes, most significant first. The register is updated after the last data bit.
- R4: The checked mode is taken from crc_mode_i while rst_n is low and holds until the next reset, whatever the pin does later.
- R5: The checksum is CRC-8 with polynomial 0x07 and an initial value of 0, processed MSB first. A checked read is header, header CRC, a zero byte, four data bytes and the CRC of those four bytes driven by the target.
- R6: A checked write is header, header CRC, four data bytes and data CRC. It is applied only when both CRCs match. Otherwise the register is unchanged and status bit 10 is set.
- R7: Address 0x01 reads the fixed value ID_VALUE (default 0x0C5E7101). Writes to it are ignored.
- R8: Status at 0x09 keeps bit 10 set until a write with bit 10 set clears it (write-one-to-clear). Resets also clear it.
- R9: The mask at 0x0D is read/write and resets to all ones, where a 1 blocks that status bit. irq_n is low exactly while some status bit is set whose mask bit is clear.
- R10: Writing 1 to bit 0 of 0x03 restores status and mask to their reset values. Address 0x03 reads zero.
- R11: Reads of any other address return zero, and writes to them change nothing. A frame with the control flag clear changes no register and the target outputs only zero bytes.
- R12: spi_miso is low while the select is high. A write frame cut short by raising the select changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SPI pins are resampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_mode_i | input | 1 | Checked-mode strap, sampled during reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions watch, on every cycle, that the error bit stays set until a register write, that a checksum failure sets it one cycle later and never coincides with a commit, that the interrupt is never low without a pending error, that no commit or output data appears with the select idle, and that the latched mode never moves. The framing itself only shows up in the bench's transactions. That covers byte ordering, the turnaround and zero bytes, the CRC values returned on reads, the rejection of corrupted or truncated writes, address aliasing and the software reset. The bench's model tracks the status and mask and compares the interrupt pin on every idle clock.

// File: rtl/spi_tgt_pkg.sv
`timescale 1ns/1ps
package spi_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam logic [7:0] CRC_POLY = 8'h07;

    // One byte of CRC-8, MSB first, from the running value crc.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mo;
        logic              sck_prev;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  sck_s;

    assign sck_s = sy_q.sck[STAGES-1];

    always_comb begin
        sy_d          = sy_q;
        sy_d.sck      = {sy_q.sck[STAGES-2:0], sclk_i};
        sy_d.csn      = {sy_q.csn[STAGES-2:0], cs_n_i};
        sy_d.mo       = {sy_q.mo[STAGES-2:0], mosi_i};
        sy_d.sck_prev = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q     <= '0;
            sy_q.csn <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sclk_rise = sck_s & ~sy_q.sck_prev;
    assign sclk_fall = ~sck_s & sy_q.sck_prev;
    assign cs_act    = ~sy_q.csn[STAGES-1];
    assign mosi_s    = sy_q.mo[STAGES-1];

endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
module spi_shift_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_act,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       mosi_s,
    input  logic [7:0] tx_next,
    output logic       miso,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    typedef struct packed {
        logic [2:0] bit_cnt;
        logic [6:0] rx_sr;
        logic [7:0] tx_sr;
        logic       done;
        logic [7:0] rx_byte;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!cs_act) begin
            sh_d.bit_cnt = '0;
            sh_d.rx_sr   = '0;
            sh_d.tx_sr   = '0;
        end else begin
            if (sclk_rise) begin
                sh_d.rx_sr   = {sh_q.rx_sr[5:0], mosi_s};
                sh_d.bit_cnt = sh_q.bit_cnt + 3'd1;
                if (sh_q.bit_cnt == 3'd7) begin
                    sh_d.done    = 1'b1;
                    sh_d.rx_byte = {sh_q.rx_sr, mosi_s};
                end
            end
            if (sclk_fall) begin
                // On a byte boundary the next outgoing byte is loaded, else shift.
                sh_d.tx_sr = (sh_q.bit_cnt == 3'd0) ? tx_next : {sh_q.tx_sr[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso      = sh_q.tx_sr[7];
    assign byte_done = sh_q.done;
    assign rx_byte   = sh_q.rx_byte;

endmodule

// File: rtl/spi_txn_decode.sv
`timescale 1ns/1ps
module spi_txn_decode
    import spi_tgt_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              crc_mode,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_set,
    output logic [7:0]        tx_next
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int IDX_W  = $clog2(NBYTES + 8) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] NB      = IDX_W'(NBYTES);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              is_cmd;
        logic              is_wr;
        logic [HI_W-1:0]   addr_hi;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        crc_run;
        logic              hdr_ok;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdw;
        logic [7:0]        rcrc;
        logic [7:0]        tx_next;
    } dec_t;

    dec_t dc_d, dc_q;

    logic [IDX_W-1:0] rd_start;   // byte index whose completion launches read data
    logic [IDX_W-1:0] wr_start;   // byte index of the first write data byte
    logic [7:0]       crc_nxt;

    assign rd_start = crc_mode ? IDX_W'(3) : IDX_W'(2);
    assign wr_start = crc_mode ? IDX_W'(3) : IDX_W'(2);
    assign crc_nxt  = crc8_step(dc_q.crc_run, rx_byte);

    always_comb begin
        dc_d    = dc_q;
        wr_en   = 1'b0;
        wr_data = dc_q.wdat;
        err_set = 1'b0;
        if (!cs_act) begin
            dc_d.idx     = '0;
            dc_d.is_cmd  = 1'b0;
            dc_d.is_wr   = 1'b0;
            dc_d.crc_run = '0;
            dc_d.hdr_ok  = 1'b1;
            dc_d.tx_next = '0;
        end else if (byte_done) begin
            dc_d.tx_next = '0;
            if (dc_q.idx != IDX_MAX) dc_d.idx = dc_q.idx + 1'b1;
            if (dc_q.idx == '0) begin
                dc_d.is_cmd  = rx_byte[7];
                dc_d.is_wr   = rx_byte[5];
                dc_d.addr_hi = rx_byte[HI_W-1:0];
                dc_d.crc_run = crc_nxt;
            end else if (dc_q.idx == IDX_W'(1)) begin
                dc_d.addr    = {dc_q.addr_hi, rx_byte};
                dc_d.crc_run = crc_nxt;
            end else if (dc_q.is_cmd) begin
                if (crc_mode && dc_q.idx == IDX_W'(2)) begin
                    dc_d.hdr_ok  = (rx_byte == dc_q.crc_run);
                    dc_d.crc_run = '0;
                    if (!dc_q.is_wr && rx_byte != dc_q.crc_run) err_set = 1'b1;
                end
                if (!dc_q.is_wr) begin
                    if (dc_q.idx == rd_start) begin
                        dc_d.tx_next = rdata[DATA_W-1 -: 8];
                        dc_d.rdw     = rdata << 8;
                        dc_d.rcrc    = crc8_step(8'h00, rdata[DATA_W-1 -: 8]);
                    end else if (dc_q.idx > rd_start && dc_q.idx < rd_start + NB) begin
                        dc_d.tx_next = dc_q.rdw[DATA_W-1 -: 8];
                        dc_d.rdw     = dc_q.rdw << 8;
                        dc_d.rcrc    = crc8_step(dc_q.rcrc, dc_q.rdw[DATA_W-1 -: 8]);
                    end else if (crc_mode && dc_q.idx == rd_start + NB) begin
                        dc_d.tx_next = dc_q.rcrc;
                    end
                end else begin
                    if (dc_q.idx >= wr_start && dc_q.idx < wr_start + NB) begin
                        dc_d.wdat    = {dc_q.wdat[DATA_W-9:0], rx_byte};
                        dc_d.crc_run = crc_nxt;
                        if (!crc_mode && dc_q.idx == wr_start + NB - 1'b1) begin
                            wr_en   = 1'b1;
                            wr_data = {dc_q.wdat[DATA_W-9:0], rx_byte};
                        end
                    end else if (crc_mode && dc_q.idx == wr_start + NB) begin
                        if (dc_q.hdr_ok && rx_byte == dc_q.crc_run) wr_en   = 1'b1;
                        else                                       err_set = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q        <= '0;
            dc_q.hdr_ok <= 1'b1;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign addr    = dc_q.addr;
    assign tx_next = dc_q.tx_next;

endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank #(
    parameter int              ADDR_W    = 13,
    parameter int              DATA_W    = 32,
    parameter logic [31:0]     ID_VALUE  = 32'h0C5E_7101,
    parameter int              ERR_BIT   = 10,
    parameter logic [12:0]     ID_ADDR   = 13'h001,
    parameter logic [12:0]     RST_ADDR  = 13'h003,
    parameter logic [12:0]     STAT_ADDR = 13'h009,
    parameter logic [12:0]     MASK_ADDR = 13'h00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_set,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] stat,
    output logic              irq_n
);

    localparam logic [DATA_W-1:0] MASK_RST = '1;

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] mask;
        logic              irq_n;
    } bank_t;

    bank_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (wr_en) begin
            case (addr)
                RST_ADDR[ADDR_W-1:0]: begin
                    if (wr_data[0]) begin
                        rb_d.stat = '0;
                        rb_d.mask = MASK_RST;
                    end
                end
                STAT_ADDR[ADDR_W-1:0]: rb_d.stat = rb_q.stat & ~wr_data;
                MASK_ADDR[ADDR_W-1:0]: rb_d.mask = wr_data;
                default: ;
            endcase
        end
        if (err_set) rb_d.stat[ERR_BIT] = 1'b1;
        rb_d.irq_n = ~|(rb_d.stat & ~rb_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q.stat  <= '0;
            rb_q.mask  <= MASK_RST;
            rb_q.irq_n <= 1'b1;
        end else begin
            rb_q <= rb_d;
        end
    end

    always_comb begin
        case (addr)
            ID_ADDR[ADDR_W-1:0]:   rdata = ID_VALUE[DATA_W-1:0];
            STAT_ADDR[ADDR_W-1:0]: rdata = rb_q.stat;
            MASK_ADDR[ADDR_W-1:0]: rdata = rb_q.mask;
            default:               rdata = '0;
        endcase
    end

    assign stat  = rb_q.stat;
    assign irq_n = rb_q.irq_n;

endmodule

// File: rtl/spi_reg_target.sv
`timescale 1ns/1ps
module spi_reg_target #(
    parameter int          ADDR_W      = 13,
    parameter int          DATA_W      = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_VALUE    = 32'h0C5E_7101,
    parameter int          ERR_BIT     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_mode_i,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic irq_n
);

    logic              sclk_rise, sclk_fall, cs_act, mosi_s;
    logic              byte_done;
    logic [7:0]        rx_byte, tx_next;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en, err_set;
    logic [DATA_W-1:0] wr_data, rdata, stat_w;
    logic              crc_mode_d, crc_mode_q;

    // The strap follows the pin only while reset is held.
    always_comb crc_mode_d = crc_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_mode_q <= crc_mode_i;
        else        crc_mode_q <= crc_mode_d;
    end

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    spi_shift_unit u_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
        .tx_next(tx_next), .miso(spi_miso), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    spi_txn_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .crc_mode(crc_mode_q),
        .byte_done(byte_done), .rx_byte(rx_byte), .rdata(rdata),
        .addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .err_set(err_set),
        .tx_next(tx_next)
    );

    spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE),
                   .ERR_BIT(ERR_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .err_set(err_set), .rdata(rdata),
        .stat(stat_w), .irq_n(irq_n)
    );

endmodule

// File: rtl/spi_reg_target_chk.sv
`timescale 1ns/1ps
module spi_reg_target_chk #(
    parameter int DATA_W  = 32,
    parameter int ERR_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              wr_en,
    input logic              err_set,
    input logic              crc_mode_q,
    input logic              irq_n,
    input logic              spi_miso,
    input logic [DATA_W-1:0] stat
);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ERR_BIT] && !wr_en) |=> stat[ERR_BIT]);

    assert_err_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> stat[ERR_BIT]);

    assert_no_commit_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && err_set));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> stat[ERR_BIT]);

    assert_write_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cs_act);

    assert_idle_miso_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(crc_mode_q));

endmodule

bind spi_reg_target spi_reg_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .wr_en(wr_en), .err_set(err_set),
    .crc_mode_q(crc_mode_q), .irq_n(irq_n), .spi_miso(spi_miso), .stat(stat_w)
);

// File: tb/spi_reg_target_bench.sv
`timescale 1ns/1ps
module spi_reg_target_bench;

    localparam logic [31:0] ID_VAL = 32'h0C5E_7101;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, crc_pin = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, irq_n;

    int checks = 0, errors = 0;
    bit busy = 1'b1, done = 1'b0;

    logic [7:0]  tb_tx[16];
    logic [7:0]  tb_rx[16];
    logic        m_crc_mode;
    logic [31:0] m_stat, m_mask;

    always #2.5 clk = ~clk;

    spi_reg_target u_spi_reg_target (
        .clk(clk), .rst_n(rst_n), .crc_mode_i(crc_pin), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso), .irq_n(irq_n)
    );

    function automatic logic [7:0] m_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ b[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model compared on every idle clock (R9).
    always @(negedge clk) begin
        if (rst_n && !busy && !done) begin
            check("R9 irq_n", {31'd0, irq_n}, {31'd0, ~|(m_stat & ~m_mask)});
            if (cs_n) check("R12 idle miso", {31'd0, miso}, 32'd0);
        end
    end

    task automatic do_reset(input logic mode);
        busy = 1'b1;
        rst_n = 1'b0;
        crc_pin = mode;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        m_crc_mode = mode;
        m_stat = 32'd0;
        m_mask = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        busy = 1'b0;
    endtask

    task automatic xfer(input int n);
        busy = 1'b1;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tb_tx[b][i];
                repeat (HALF) @(negedge clk);
                sclk = 1'b1;
                tb_rx[b][i] = miso;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
    endtask

    task automatic finish_xfer();
        repeat (12) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [31:0] d, input bit cmd,
                            input bit bad_h, input bit bad_d, input int trunc);
        int n;
        logic [7:0] c;
        tb_tx[0] = {cmd, 1'b0, 1'b1, a[12:8]};
        tb_tx[1] = a[7:0];
        n = 2;
        if (m_crc_mode) begin
            c = m_crc(m_crc(8'h00, tb_tx[0]), tb_tx[1]);
            tb_tx[2] = bad_h ? ~c : c;
            n = 3;
        end
        c = 8'h00;
        for (int k = 0; k < 4; k++) begin
            tb_tx[n] = d[31 - 8*k -: 8];
            c = m_crc(c, tb_tx[n]);
            n++;
        end
        if (m_crc_mode) begin
            tb_tx[n] = bad_d ? (c ^ 8'h01) : c;
            n++;
        end
        xfer(n - trunc);
        if (trunc == 0 && cmd) begin
            if (m_crc_mode && (bad_h || bad_d)) m_stat[10] = 1'b1;
            else begin
                case (a)
                    13'h003: if (d[0]) begin m_stat = 32'd0; m_mask = 32'hFFFF_FFFF; end
                    13'h009: m_stat = m_stat & ~d;
                    13'h00D: m_mask = d;
                    default: ;
                endcase
            end
        end
        finish_xfer();
    endtask

    task automatic do_read(input logic [12:0] a, output logic [31:0] v, output logic [7:0] crc_rx,
                           output logic [7:0] gap);
        int n, s;
        tb_tx[0] = {1'b1, 1'b0, 1'b0, a[12:8]};
        tb_tx[1] = a[7:0];
        n = 2;
        if (m_crc_mode) begin
            tb_tx[2] = m_crc(m_crc(8'h00, tb_tx[0]), tb_tx[1]);
            n = 3;
        end
        tb_tx[n] = 8'h00;
        gap = 8'h00;
        s = n + 1;
        for (int k = 0; k < 5; k++) tb_tx[s + k] = 8'h00;
        xfer(s + (m_crc_mode ? 5 : 4));
        gap = tb_rx[n];
        v = {tb_rx[s], tb_rx[s+1], tb_rx[s+2], tb_rx[s+3]};
        crc_rx = m_crc_mode ? tb_rx[s+4] : 8'h00;
        finish_xfer();
    endtask

    function automatic logic [7:0] word_crc(input logic [31:0] w);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < 4; k++) c = m_crc(c, w[31 - 8*k -: 8]);
        return c;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  cr, gp;
        bit          all_zero;

        // Plain mode
        do_reset(1'b0);
        check("R9 reset irq_n", {31'd0, irq_n}, 32'd1);
        check("R12 reset miso", {31'd0, miso}, 32'd0);
        do_read(13'h001, v, cr, gp);
        check("R7 id read", v, ID_VAL);
        check("R2 turnaround byte zero", {24'd0, gp}, 32'd0);
        do_read(13'h00D, v, cr, gp);
        check("R9 mask reset", v, 32'hFFFF_FFFF);
        do_read(13'h009, v, cr, gp);
        check("R8 status reset", v, 32'd0);

        do_write(13'h00D, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h00D, v, cr, gp);
        check("R3 mask write order", v, 32'h1234_5678);

        // Address bits 12:8 decoded (R1), unimplemented address (R11)
        do_write(13'h10D, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h00D, v, cr, gp);
        check("R1 high address no alias", v, 32'h1234_5678);
        do_read(13'h10D, v, cr, gp);
        check("R11 unimplemented reads zero", v, 32'd0);

        do_write(13'h001, 32'h0, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h001, v, cr, gp);
        check("R7 id write ignored", v, ID_VAL);

        // Control flag clear: ignored, zero output (R11)
        do_write(13'h00D, 32'hAAAA_5555, 1'b0, 1'b0, 1'b0, 0);
        all_zero = 1'b1;
        for (int k = 0; k < 6; k++) if (tb_rx[k] != 8'h00) all_zero = 1'b0;
        check("R11 non-control frame output", {31'd0, all_zero}, 32'd1);
        do_read(13'h00D, v, cr, gp);
        check("R11 non-control frame ignored", v, 32'h1234_5678);

        // Truncated write (R12)
        do_write(13'h00D, 32'h0BAD_0BAD, 1'b1, 1'b0, 1'b0, 1);
        do_read(13'h00D, v, cr, gp);
        check("R12 truncated write dropped", v, 32'h1234_5678);

        // Checked mode
        do_reset(1'b1);
        crc_pin = 1'b0;   // R4: pin changes after reset must not matter
        repeat (10) @(negedge clk);
        do_read(13'h001, v, cr, gp);
        check("R4 mode held, id read", v, ID_VAL);
        check("R5 read crc", {24'd0, cr}, {24'd0, word_crc(ID_VAL)});
        check("R5 zero byte", {24'd0, gp}, 32'd0);

        do_write(13'h00D, 32'hFFFF_FBFF, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h00D, v, cr, gp);
        check("R6 good crc write applied", v, 32'hFFFF_FBFF);
        check("R5 mask read crc", {24'd0, cr}, {24'd0, word_crc(32'hFFFF_FBFF)});

        do_write(13'h00D, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 0);
        do_read(13'h00D, v, cr, gp);
        check("R6 bad data crc write dropped", v, 32'hFFFF_FBFF);
        do_read(13'h009, v, cr, gp);
        check("R8 error bit set", v, 32'h0000_0400);
        check("R9 irq asserted", {31'd0, irq_n}, 32'd0);

        do_write(13'h009, 32'h0000_0400, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h009, v, cr, gp);
        check("R8 write one clears", v, 32'd0);
        check("R9 irq released", {31'd0, irq_n}, 32'd1);

        do_write(13'h00D, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 0);
        do_read(13'h00D, v, cr, gp);
        check("R6 bad header crc write dropped", v, 32'hFFFF_FBFF);
        do_read(13'h009, v, cr, gp);
        check("R6 header crc error flagged", v, 32'h0000_0400);

        do_write(13'h00D, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 0);
        check("R9 masked error no irq", {31'd0, irq_n}, 32'd1);
        do_write(13'h00D, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 0);
        check("R9 unmasked error irq", {31'd0, irq_n}, 32'd0);

        do_write(13'h003, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 0);
        do_read(13'h009, v, cr, gp);
        check("R10 reset clears status", v, 32'd0);
        do_read(13'h00D, v, cr, gp);
        check("R10 reset restores mask", v, 32'hFFFF_FFFF);
        do_read(13'h003, v, cr, gp);
        check("R10 reset reg reads zero", v, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule